// File: doc/BRIEF.md
# Serial Receive Byte Queue with Status

This block holds the bytes that arrive on the line side of a serial port until software collects them. A byte strobe from the deserializer stores a byte. A break strobe stores a zero byte and records the break condition. Software takes bytes one at a time through a pop strobe. The byte that a pop would return is always visible on the data output. The block has two modes. With the queue enabled, bytes are kept in a ring of `DEPTH` entries. With it disabled, the newest byte simply overwrites a single holding register.

The block builds a 32-bit status word from its internal state. This word carries the receive fill count, the receive full flag, a pending-line-error flag, and the occupancy of the transmit side. For the transmit side the block tracks only the occupancy count, fed by load and drain strobes. A small control word turns the queue on and off and clears either side. A 4-bit line error word collects overrun, parity, frame and break conditions, and a read strobe clears it. One-cycle receive-event and error pulses feed an interrupt combiner that sits outside the block.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset, the status word is 0, `rx_ready` is 0, `rx_data` is 0, `cfg_rdata` is 0, `lerr_word` is 0, and both pulses are 0.
- R2: A write to `cfg_wr` acts on `cfg_wdata` as follows. Bit 0 enables the queue. Bit 1 empties the receive queue and drops `rx_ready`; a byte received in that same cycle is discarded. Bit 2 zeroes the transmit count. `cfg_rdata` returns the enable in bit 0, and bits 2:1 always read 0.
- R3: With the queue enabled, bytes come out in arrival order, and up to `DEPTH` bytes are held. Status bits 7:0 give the receive count.
- R4: When the receive queue holds `DEPTH` bytes, status bit 8 is 1 and bits 7:0 read 0.
- R5: A pop while the queue is enabled and empty shows 0 on `rx_data`. It also raises `rx_error_pulse` in the next cycle.
- R6: A byte that arrives while the queue is full is dropped and raises `rx_error_pulse` in the next cycle. Every byte or break strobe raises `rx_event_pulse` in the next cycle.
- R7: When a push and a pop occur in the same cycle on a queue that is neither empty nor full, both take effect and the count stays the same.
- R8: `rx_ready` rises in the cycle after a byte is stored. It falls after a pop that leaves the queue empty, provided no byte arrives in that same cycle.
- R9: With the queue disabled, each received byte overwrites the holding register and sets `rx_ready`. `rx_data` shows the holding register, and a pop clears `rx_ready`.
- R10: `lerr_word` holds overrun in bit 0, parity in bit 1, frame in bit 2 and break in bit 3. Its bits are sticky. A read strobe clears them, but a condition reported in the same cycle as the read still sets its bit. Status bit 9 is 1 whenever `lerr_word` is nonzero.
- R11: A break strobe stores a zero byte under the same mode and drop rules as a normal byte, and it sets the break bit of `lerr_word`.
- R12: Status bits 23:16 give the transmit count and bit 24 is set when that count equals `TX_DEPTH`. A load strobe at the limit, or a drain strobe at zero, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 3 | Control word: enable, receive clear, transmit clear |
| cfg_rdata | output | 3 | Control word readback |
| line_push | input | 1 | Received byte strobe |
| line_byte | input | 8 | Received byte |
| line_break | input | 1 | Break event strobe |
| line_errs | input | 3 | Overrun, parity, frame conditions |
| rx_pop | input | 1 | Data port read strobe |
| rx_data | output | 8 | Byte a pop returns |
| rx_ready | output | 1 | Data-ready flag |
| fifo_status | output | 32 | Packed queue status word |
| lerr_rd | input | 1 | Line error word read strobe |
| lerr_word | output | 4 | Line error word |
| tx_load | input | 1 | Transmit byte loaded |
| tx_drain | input | 1 | Transmit byte sent |
| rx_event_pulse | output | 1 | Receive source pulse |
| rx_error_pulse | output | 1 | Error source pulse |

## Verification
The bound assertions check several rules on every cycle. The receive count never exceeds the depth, and the count field reads zero whenever the full flag is up. A pop on an empty queue and a byte arriving at a full queue each produce an error pulse. A full queue does not change when a byte arrives alone, and a simultaneous push and pop leaves the count unchanged. Break and read-clear also behave correctly on the line error word. Other properties need whole scenarios, and only the bench's reference queue model can show them. These are byte ordering through wraparound, the zero byte left by a break, the holding-register mode, and clears that collide with incoming bytes.

// File: rtl/serq_pkg.sv
package serq_pkg;
   localparam int BYTE_W   = 8;
   localparam int CTL_EN   = 0;
   localparam int CTL_RXCL = 1;
   localparam int CTL_TXCL = 2;
   localparam int LE_W     = 4;
   localparam int ST_W     = 32;
endpackage

// File: rtl/serq_ring.sv
module serq_ring
   import serq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [BYTE_W-1:0] din,
   input  logic              pop,
   output logic [BYTE_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty
);
   logic [BYTE_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr, wnext, rnext;
   logic              do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wnext = wptr + 1'b1;
         assign rnext = rptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wnext = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rnext = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wnext;
         if (do_pop)  rptr <= rnext;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/serq_level.sv
module serq_level #(
   parameter int LIMIT = 16,
   localparam int LVL_W = $clog2(LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             dec,
   output logic [LVL_W-1:0] level,
   output logic             at_limit
);
   logic up, down;

   assign at_limit = (level == LVL_W'(LIMIT));
   assign up       = inc & ~at_limit;
   assign down     = dec & (level != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        level <= '0;
      else if (clr)      level <= '0;
      else if (up & ~down) level <= level + 1'b1;
      else if (down & ~up) level <= level - 1'b1;
   end
endmodule

// File: rtl/serq_lerr.sv
module serq_lerr
   import serq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd,
   input  logic [LE_W-1:0] set,
   output logic [LE_W-1:0] word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word <= '0;
      else        word <= (rd ? '0 : word) | set;
   end
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
   import serq_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int TX_DEPTH = 16,
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int TXC_W   = $clog2(TX_DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [2:0]  cfg_wdata,
   output logic [2:0]  cfg_rdata,
   input  logic        line_push,
   input  logic [7:0]  line_byte,
   input  logic        line_break,
   input  logic [2:0]  line_errs,
   input  logic        rx_pop,
   output logic [7:0]  rx_data,
   output logic        rx_ready,
   output logic [31:0] fifo_status,
   input  logic        lerr_rd,
   output logic [3:0]  lerr_word,
   input  logic        tx_load,
   input  logic        tx_drain,
   output logic        rx_event_pulse,
   output logic        rx_error_pulse
);
   generate
      if (DEPTH < 2 || DEPTH > 255) begin : g_bad_depth
         $error("DEPTH must lie in 2..255 to fit the count field");
      end
      if (TX_DEPTH < 2 || TX_DEPTH > 255) begin : g_bad_txdepth
         $error("TX_DEPTH must lie in 2..255 to fit the count field");
      end
   endgenerate

   logic              q_en;
   logic              rx_clr, tx_clr;
   logic              pushv;
   logic [BYTE_W-1:0] push_byte;
   logic [BYTE_W-1:0] rq_head, hold;
   logic [CNT_W-1:0]  rq_count;
   logic              rq_full, rq_empty;
   logic [TXC_W-1:0]  tx_count;
   logic              tx_full;

   assign rx_clr    = cfg_wr & cfg_wdata[CTL_RXCL];
   assign tx_clr    = cfg_wr & cfg_wdata[CTL_TXCL];
   assign pushv     = line_push | line_break;
   assign push_byte = line_break ? '0 : line_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_en <= 1'b0;
      else if (cfg_wr) q_en <= cfg_wdata[CTL_EN];
   end
   assign cfg_rdata = {2'b00, q_en};

   serq_ring #(.DEPTH(DEPTH)) ring_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_clr),
      .push  (q_en & pushv),
      .din   (push_byte),
      .pop   (q_en & rx_pop),
      .head  (rq_head),
      .count (rq_count),
      .full  (rq_full),
      .empty (rq_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               hold <= '0;
      else if (!q_en && pushv)  hold <= push_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rx_ready <= 1'b0;
      else if (rx_clr) rx_ready <= 1'b0;
      else if (pushv)  rx_ready <= 1'b1;
      else if (rx_pop && (!q_en || rq_count == CNT_W'(1))) rx_ready <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_event_pulse <= 1'b0;
         rx_error_pulse <= 1'b0;
      end else begin
         rx_event_pulse <= pushv;
         rx_error_pulse <= q_en & ((rx_pop & rq_empty) | (pushv & rq_full));
      end
   end

   assign rx_data = q_en ? (rq_empty ? '0 : rq_head) : hold;

   serq_level #(.LIMIT(TX_DEPTH)) txlvl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (tx_clr),
      .inc      (tx_load),
      .dec      (tx_drain),
      .level    (tx_count),
      .at_limit (tx_full)
   );

   serq_lerr lerr_i (
      .clk  (clk),
      .rst_n(rst_n),
      .rd   (lerr_rd),
      .set  ({line_break, line_errs}),
      .word (lerr_word)
   );

   always_comb begin
      fifo_status        = '0;
      fifo_status[7:0]   = rq_full ? 8'h00 : 8'(rq_count);
      fifo_status[8]     = rq_full;
      fifo_status[9]     = |lerr_word;
      fifo_status[23:16] = 8'(tx_count);
      fifo_status[24]    = tx_full;
   end
endmodule

// File: rtl/serq_rx_checker.sv
module serq_rx_checker #(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             q_en,
   input logic             rx_clr,
   input logic             line_push,
   input logic             line_break,
   input logic [2:0]       line_errs,
   input logic             rx_pop,
   input logic             lerr_rd,
   input logic [CNT_W-1:0] rq_count,
   input logic             rq_full,
   input logic             rq_empty,
   input logic [31:0]      fifo_status,
   input logic [3:0]       lerr_word,
   input logic             rx_event_pulse,
   input logic             rx_error_pulse
);
   // R3: count never exceeds the depth
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rq_count <= CNT_W'(DEPTH));

   // R4: full flag forces the count field to zero
   a_r4_full_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_status[8] |-> (fifo_status[7:0] == 8'h00));

   // R5: empty pop in queue mode flags an error
   a_r5_empty_pop_err: assert property (@(posedge clk) disable iff (!rst_n)
      (q_en && rx_pop && rq_empty) |=> rx_error_pulse);

   // R6: arrival at full flags an error, every arrival flags an event
   a_r6_overflow_err: assert property (@(posedge clk) disable iff (!rst_n)
      (q_en && (line_push || line_break) && rq_full) |=> rx_error_pulse);
   a_r6_event_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (line_push || line_break) |=> rx_event_pulse);

   // R6: a lone arrival at full leaves the count alone
   a_r6_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
      (q_en && rq_full && line_push && !rx_pop && !rx_clr) |=> $stable(rq_count));

   // R7: simultaneous push and pop keep the count
   a_r7_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (q_en && line_push && rx_pop && !rq_full && !rq_empty && !rx_clr)
      |=> $stable(rq_count));

   // R10: a read with no new condition clears the word
   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (lerr_rd && !line_break && line_errs == 3'b000) |=> (lerr_word == 4'h0));

   // R11: break always sets the break bit
   a_r11_break_bit: assert property (@(posedge clk) disable iff (!rst_n)
      line_break |=> lerr_word[3]);
endmodule

bind serial_rx_queue serq_rx_checker #(.DEPTH(DEPTH)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .q_en           (q_en),
   .rx_clr         (rx_clr),
   .line_push      (line_push),
   .line_break     (line_break),
   .line_errs      (line_errs),
   .rx_pop         (rx_pop),
   .lerr_rd        (lerr_rd),
   .rq_count       (rq_count),
   .rq_full        (rq_full),
   .rq_empty       (rq_empty),
   .fifo_status    (fifo_status),
   .lerr_word      (lerr_word),
   .rx_event_pulse (rx_event_pulse),
   .rx_error_pulse (rx_error_pulse)
);

// File: tb/serial_rx_queue_tb_top.sv
module serial_rx_queue_tb_top;
   localparam int DEPTH = 16;
   localparam int TXD   = 16;

   logic        clk, rst_n;
   logic        cfg_wr;
   logic [2:0]  cfg_wdata, cfg_rdata;
   logic        line_push, line_break, rx_pop, lerr_rd, tx_load, tx_drain;
   logic [7:0]  line_byte, rx_data;
   logic [2:0]  line_errs;
   logic        rx_ready, rx_event_pulse, rx_error_pulse;
   logic [31:0] fifo_status;
   logic [3:0]  lerr_word;

   serial_rx_queue #(.DEPTH(DEPTH), .TX_DEPTH(TXD)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .line_push(line_push), .line_byte(line_byte),
      .line_break(line_break), .line_errs(line_errs), .rx_pop(rx_pop),
      .rx_data(rx_data), .rx_ready(rx_ready), .fifo_status(fifo_status),
      .lerr_rd(lerr_rd), .lerr_word(lerr_word), .tx_load(tx_load),
      .tx_drain(tx_drain), .rx_event_pulse(rx_event_pulse),
      .rx_error_pulse(rx_error_pulse));

   initial clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   // reference model state
   logic [7:0] mq[$];
   logic       m_en, m_rdy, m_errp, m_evp;
   logic [7:0] m_hold;
   logic [3:0] m_le;
   int         m_tx;
   int         n_chk = 0, n_bad = 0;
   bit         done = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic [31:0] st;
      logic [7:0]  d;
      bit          f;
      f  = (mq.size() == DEPTH);
      st = '0;
      st[7:0]   = f ? 8'h00 : 8'(mq.size());
      st[8]     = f;
      st[9]     = |m_le;
      st[23:16] = 8'(m_tx);
      st[24]    = (m_tx == TXD);
      d = m_en ? ((mq.size() > 0) ? mq[0] : 8'h00) : m_hold;
      chk("R3 rx count",        {24'h0, fifo_status[7:0]}, {24'h0, st[7:0]});
      chk("R4 rx full",         {31'h0, fifo_status[8]},   {31'h0, st[8]});
      chk("R10 err flag",       {31'h0, fifo_status[9]},   {31'h0, st[9]});
      chk("R12 tx field",       {7'h0, fifo_status[24:16]}, {7'h0, st[24:16]});
      chk("R5/R9 rx_data",      {24'h0, rx_data},          {24'h0, d});
      chk("R8 rx_ready",        {31'h0, rx_ready},         {31'h0, m_rdy});
      chk("R6 event pulse",     {31'h0, rx_event_pulse},   {31'h0, m_evp});
      chk("R6 error pulse",     {31'h0, rx_error_pulse},   {31'h0, m_errp});
      chk("R10 lerr_word",      {28'h0, lerr_word},        {28'h0, m_le});
      chk("R2 cfg_rdata",       {29'h0, cfg_rdata},        {29'h0, 2'b00, m_en});
   endtask

   task automatic model_step();
      int         sz;
      bit         pv;
      logic [7:0] pb;
      sz = mq.size();
      pv = line_push | line_break;
      pb = line_break ? 8'h00 : line_byte;
      m_evp  = pv;
      m_errp = 0;
      if (m_en) begin
         if (rx_pop && sz == 0)   m_errp = 1;
         if (pv && sz == DEPTH)   m_errp = 1;
         if (rx_pop && sz > 0)    void'(mq.pop_front());
         if (pv && sz < DEPTH)    mq.push_back(pb);
         if (pv) m_rdy = 1;
         else if (rx_pop && sz == 1) m_rdy = 0;
      end else begin
         if (pv) begin m_hold = pb; m_rdy = 1; end
         else if (rx_pop) m_rdy = 0;
      end
      m_le = (lerr_rd ? 4'h0 : m_le) | {line_break, line_errs};
      m_tx = m_tx + ((tx_load && m_tx < TXD) ? 1 : 0) - ((tx_drain && m_tx > 0) ? 1 : 0);
      if (cfg_wr) begin
         m_en = cfg_wdata[0];
         if (cfg_wdata[1]) begin mq.delete(); m_rdy = 0; end
         if (cfg_wdata[2]) m_tx = 0;
      end
   endtask

   task automatic idle_inputs();
      cfg_wr = 0; cfg_wdata = 0; line_push = 0; line_byte = 0; line_break = 0;
      line_errs = 0; rx_pop = 0; lerr_rd = 0; tx_load = 0; tx_drain = 0;
   endtask

   task automatic cyc();
      #5;
      compare_all();
      @(posedge clk);
      model_step();
      #1;
      idle_inputs();
   endtask

   task automatic do_cfg(logic [2:0] w); cfg_wr = 1; cfg_wdata = w; cyc(); endtask
   task automatic do_push(logic [7:0] b); line_push = 1; line_byte = b; cyc(); endtask
   task automatic do_pop(); rx_pop = 1; cyc(); endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      m_en = 0; m_rdy = 0; m_errp = 0; m_evp = 0; m_hold = 0; m_le = 0; m_tx = 0;
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #5;
      // R1: reset state at the ports
      chk("R1 status", fifo_status, 32'h0);
      chk("R1 ready/pulses", {29'h0, rx_ready, rx_event_pulse, rx_error_pulse}, 32'h0);
      chk("R1 data/cfg/lerr", {17'h0, rx_data, cfg_rdata, lerr_word}, 32'h0);
      @(posedge clk); #1;

      // R2: enable queue mode
      do_cfg(3'b001);
      // R3: ordered storage, R7: push+pop together
      do_push(8'h11); do_push(8'h22); do_push(8'h33);
      do_pop();
      line_push = 1; line_byte = 8'h44; rx_pop = 1; cyc();   // R7
      do_pop(); do_pop(); do_pop();                          // R8 ready drops
      do_pop();                                              // R5 empty pop
      cyc();

      // R4/R6: fill, overflow, wraparound
      for (int i = 0; i < DEPTH; i++) do_push(8'(i * 7 + 1));
      do_push(8'hEE);                                        // R6 dropped
      line_push = 1; line_byte = 8'hDD; rx_pop = 1; cyc();   // dropped, pop ok
      for (int i = 0; i < DEPTH; i++) do_pop();
      do_pop();

      // R11: break stores zero byte and sets break bit
      do_push(8'h5A);
      line_break = 1; cyc();
      do_pop(); do_pop();

      // R10: sticky error bits, read clears, set wins
      line_errs = 3'b101; cyc();
      line_errs = 3'b010; cyc();
      lerr_rd = 1; cyc();
      line_errs = 3'b001; cyc();
      lerr_rd = 1; line_errs = 3'b100; cyc();
      lerr_rd = 1; cyc();

      // R12: transmit count, limit, drain, both, clear
      for (int i = 0; i < TXD + 2; i++) begin tx_load = 1; cyc(); end
      tx_load = 1; tx_drain = 1; cyc();
      tx_drain = 1; cyc();
      tx_load = 1; tx_drain = 1; cyc();
      do_cfg(3'b101);                                        // R2 tx clear
      tx_drain = 1; cyc();

      // R2: receive clear with bytes pending and a colliding byte
      do_push(8'hA1); do_push(8'hA2);
      line_push = 1; line_byte = 8'hA3; cfg_wr = 1; cfg_wdata = 3'b011; cyc();
      cyc();

      // R9: holding-register mode
      do_cfg(3'b000);
      do_push(8'hA5);
      do_push(8'h3C);
      do_pop();
      do_pop();
      line_break = 1; cyc();                                 // R11 in holding mode
      do_cfg(3'b001);
      do_push(8'h77); do_pop(); cyc();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule